// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block guards the decode stage of a five-stage in-order pipeline. A load that is in the execute stage does not have its data until it leaves the memory stage. If the instruction now in decode reads the register that this load writes, that instruction has to wait one cycle. The controller detects this case. For that one cycle it holds the program counter and the fetch/decode pipeline register. It also forces the control bundle sent toward execute to all zeros, so a bubble enters the pipeline in place of the waiting instruction.

The block contains a small model of the program counter and of the fetch/decode instruction register. Because of this, the stall can be seen directly at the ports, cycle by cycle. The execute stage drives two inputs: its memory-read flag and its destination register number. The decoder supplies the control bundle for the held instruction. The instruction word uses a fixed layout: source register A in bits 25:21, source register B in bits 20:16, and the opcode and the remaining fields elsewhere.

Top module: `load_use_stall`

## Requirements
- R1: The stall (`ctrl_zero`=1, `pc_we`=0, `ifid_we`=0) is raised in the same cycle whenever `ex_mem_read`=1 and `ex_rt` equals bits 25:21 or bits 20:16 of `ifid_instr`. In every other cycle `ctrl_zero`=0, `pc_we`=1 and `ifid_we`=1.
- R2: While stalled, `idex_ctrl` is all zeros. Otherwise `idex_ctrl` equals `dec_ctrl`.
- R3: On a rising edge without a stall, `ifid_instr` takes `fetch_instr`. On a stalled edge, `ifid_instr` keeps its value.
- R4: On a rising edge without a stall, `pc` advances by 4. On a stalled edge, `pc` keeps its value, so the same address is fetched again.
- R5: While `rst_n` is low, `pc` returns to RESET_PC (default 0) and `ifid_instr` returns to 0 at the next rising edge.
- R6: When `ex_mem_read`=0, no stall occurs, even if `ex_rt` matches a source field.
- R7: A load followed directly by a dependent instruction causes exactly one stall cycle. The dependent instruction is presented in decode for two cycles, and then the next instruction follows.
- R8: A match between `ex_rt` and bits 15:11, the offset field 15:0 or the opcode field 31:26 of `ifid_instr` does not cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_instr | input | 32 | Instruction word read at the current `pc` |
| dec_ctrl | input | 9 | Control bundle decoded from `ifid_instr` |
| ex_mem_read | input | 1 | Execute-stage instruction reads memory |
| ex_rt | input | 5 | Execute-stage destination register |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register load enable |
| ctrl_zero | output | 1 | Bubble select for the control bundle |
| pc | output | 32 | Program counter |
| ifid_instr | output | 32 | Instruction held in decode |
| idex_ctrl | output | 9 | Control bundle passed toward execute |

## Verification
The stall flags and `idex_ctrl` are combinational. They are due in the same cycle as the execute inputs and the decode word they depend on. The bench drives inputs on the falling edge and samples these outputs one nanosecond later. `pc` and `ifid_instr` change on the next rising edge. For these, the bench records their values before that edge and compares the new values one nanosecond after it: a hold on a stall, an advance or a load otherwise. The load-use sequence is run cycle by cycle to confirm that exactly one stall appears and that decode repeats the dependent instruction exactly once.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int CTRL_W  = 9,
  parameter int REG_W   = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] fetch_instr,
  input  logic [CTRL_W-1:0]  dec_ctrl,
  input  logic               ex_mem_read,
  input  logic [REG_W-1:0]   ex_rt,
  output logic               pc_we,
  output logic               ifid_we,
  output logic               ctrl_zero,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] ifid_instr,
  output logic [CTRL_W-1:0]  idex_ctrl
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_W / 8);

  logic [REG_W-1:0] src_a, src_b;
  logic             hit;

  assign src_a = ifid_instr[RS_LSB +: REG_W];
  assign src_b = ifid_instr[RT_LSB +: REG_W];
  assign hit   = ex_mem_read && ((ex_rt == src_a) || (ex_rt == src_b));

  assign ctrl_zero = hit;
  assign pc_we     = !hit;
  assign ifid_we   = !hit;
  assign idex_ctrl = hit ? '0 : dec_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      ifid_instr <= '0;
    end else begin
      if (pc_we)   pc         <= pc + PC_STEP;
      if (ifid_we) ifid_instr <= fetch_instr;
    end
  end
endmodule

// File: rtl/load_use_stall_chk.sv
module load_use_stall_chk #(
  parameter int PC_W    = 32,
  parameter int INSTR_W = 32,
  parameter int CTRL_W  = 9,
  parameter int REG_W   = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [INSTR_W-1:0] fetch_instr,
  input logic [CTRL_W-1:0]  dec_ctrl,
  input logic               ex_mem_read,
  input logic [REG_W-1:0]   ex_rt,
  input logic               pc_we,
  input logic               ifid_we,
  input logic               ctrl_zero,
  input logic [PC_W-1:0]    pc,
  input logic [INSTR_W-1:0] ifid_instr,
  input logic [CTRL_W-1:0]  idex_ctrl
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_W / 8);

  logic match_a, match_b;
  assign match_a = (ex_rt == ifid_instr[RS_LSB +: REG_W]);
  assign match_b = (ex_rt == ifid_instr[RT_LSB +: REG_W]);

  p_stall_on_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_read && (match_a || match_b)) |-> (!pc_we && !ifid_we && ctrl_zero));

  p_bubble_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero |-> (idex_ctrl == '0));

  p_pass_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_zero |-> (idex_ctrl == dec_ctrl));

  p_ifid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ifid_we && rst_n) |=> $stable(ifid_instr));

  p_ifid_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_we |=> (ifid_instr == $past(fetch_instr)));

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc));

  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc == $past(pc) + STEP));

  p_reset_r5: assert property (@(posedge clk)
    !rst_n |=> (pc == RESET_PC && ifid_instr == '0));

  p_no_read_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_read |-> (pc_we && ifid_we && !ctrl_zero));

  p_other_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_a && !match_b) |-> (pc_we && !ctrl_zero));
endmodule

bind load_use_stall load_use_stall_chk #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .CTRL_W(CTRL_W), .REG_W(REG_W),
  .RS_LSB(RS_LSB), .RT_LSB(RT_LSB), .RESET_PC(RESET_PC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
  .ex_mem_read(ex_mem_read), .ex_rt(ex_rt), .pc_we(pc_we), .ifid_we(ifid_we),
  .ctrl_zero(ctrl_zero), .pc(pc), .ifid_instr(ifid_instr), .idex_ctrl(idex_ctrl)
);

// File: tb/load_use_stall_tb_top.sv
module load_use_stall_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_instr = '0;
  logic [8:0]  dec_ctrl = '0;
  logic        ex_mem_read = 1'b0;
  logic [4:0]  ex_rt = '0;
  logic        pc_we, ifid_we, ctrl_zero;
  logic [31:0] pc, ifid_instr;
  logic [8:0]  idex_ctrl;

  int n_chk = 0;
  int n_bad = 0;
  int n_stall = 0;

  always #5 clk = ~clk;

  load_use_stall dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr), .dec_ctrl(dec_ctrl),
    .ex_mem_read(ex_mem_read), .ex_rt(ex_rt), .pc_we(pc_we), .ifid_we(ifid_we),
    .ctrl_zero(ctrl_zero), .pc(pc), .ifid_instr(ifid_instr), .idex_ctrl(idex_ctrl)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] low);
    return {op, a, b, low};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] f, input logic mr, input logic [4:0] rt,
                      input logic [8:0] c, input logic exp_stall, input string tag);
    logic [31:0] p0, i0;
    @(negedge clk);
    fetch_instr = f; ex_mem_read = mr; ex_rt = rt; dec_ctrl = c;
    #1;
    chk({tag, " ctrl_zero"}, 32'(ctrl_zero), 32'(exp_stall));
    chk({tag, " pc_we"}, 32'(pc_we), 32'(!exp_stall));
    chk({tag, " ifid_we"}, 32'(ifid_we), 32'(!exp_stall));
    chk({tag, " idex_ctrl R2"}, 32'(idex_ctrl), exp_stall ? 32'd0 : 32'(c));
    if (ctrl_zero) n_stall++;
    p0 = pc; i0 = ifid_instr;
    @(posedge clk); #1;
    chk({tag, " pc R4"}, pc, exp_stall ? p0 : p0 + 32'd4);
    chk({tag, " ifid R3"}, ifid_instr, exp_stall ? i0 : f);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0; ex_mem_read = 1'b0;
    @(posedge clk); #1;
    chk("R5 pc after reset", pc, 32'd0);
    chk("R5 ifid after reset", ifid_instr, 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_flow;
    step(mk(6'h00, 5'd1, 5'd2, 16'h1800), 1'b0, 5'd0, 9'h1a5, 1'b0, "R6 flow a");
    step(mk(6'h08, 5'd3, 5'd4, 16'h0010), 1'b0, 5'd0, 9'h0f3, 1'b0, "R6 flow b");
    step(mk(6'h23, 5'd5, 5'd6, 16'hfffc), 1'b0, 5'd9, 9'h101, 1'b0, "R6 flow c");
  endtask

  task automatic t_rs_match;
    step(mk(6'h00, 5'd12, 5'd13, 16'h0000), 1'b0, 5'd0, 9'h000, 1'b0, "R1 rs load");
    step(mk(6'h00, 5'd1, 5'd1, 16'h0000), 1'b1, 5'd12, 9'h1ff, 1'b1, "R1 rs stall");
    step(mk(6'h00, 5'd1, 5'd1, 16'h0000), 1'b0, 5'd12, 9'h1ff, 1'b0, "R1 rs after");
  endtask

  task automatic t_rt_match;
    step(mk(6'h2b, 5'd20, 5'd17, 16'h0004), 1'b0, 5'd0, 9'h000, 1'b0, "R1 rt load");
    step(mk(6'h00, 5'd2, 5'd2, 16'h0000), 1'b1, 5'd17, 9'h0aa, 1'b1, "R1 rt stall");
    step(mk(6'h00, 5'd2, 5'd2, 16'h0000), 1'b1, 5'd3, 9'h0aa, 1'b0, "R1 no match");
  endtask

  task automatic t_no_read;
    step(mk(6'h00, 5'd9, 5'd10, 16'h0000), 1'b0, 5'd2, 9'h000, 1'b0, "R6 load");
    step(mk(6'h00, 5'd4, 5'd4, 16'h0000), 1'b0, 5'd9, 9'h155, 1'b0, "R6 rs no read");
    step(mk(6'h00, 5'd4, 5'd4, 16'h0000), 1'b0, 5'd4, 9'h155, 1'b0, "R6 rt no read");
  endtask

  task automatic t_other_fields;
    step(mk(6'h07, 5'd1, 5'd2, {5'd7, 11'h015}), 1'b0, 5'd0, 9'h000, 1'b0, "R8 load");
    step(mk(6'h00, 5'd5, 5'd5, 16'h0000), 1'b1, 5'd7, 9'h0c3, 1'b0, "R8 rd field");
    step(mk(6'h00, 5'd5, 5'd5, 16'h0000), 1'b1, 5'd5, 9'h0c3, 1'b1, "R8 sanity");
    step(mk(6'h00, 5'd6, 5'd6, 16'h0000), 1'b1, 5'd5, 9'h0c3, 1'b1, "R8 still held");
    step(mk(6'h00, 5'd6, 5'd6, 16'h0000), 1'b1, 5'd21, 9'h0c3, 1'b0, "R8 offset bits");
  endtask

  task automatic t_one_bubble;
    logic [31:0] ld, use_i, nxt;
    int s0;
    ld    = mk(6'h23, 5'd1, 5'd8, 16'h0020);
    use_i = mk(6'h00, 5'd8, 5'd3, 16'h2020);
    nxt   = mk(6'h00, 5'd4, 5'd5, 16'h3020);
    s0 = n_stall;
    step(ld, 1'b0, 5'd0, 9'h000, 1'b0, "R7 fetch load");
    step(use_i, 1'b0, 5'd0, 9'h0f0, 1'b0, "R7 decode load");
    step(use_i, 1'b1, 5'd8, 9'h088, 1'b1, "R7 stall cycle");
    chk("R7 use held in decode", ifid_instr, use_i);
    step(nxt, 1'b0, 5'd0, 9'h088, 1'b0, "R7 bubble ahead");
    chk("R7 next instr enters", ifid_instr, nxt);
    chk("R7 stall count", 32'(n_stall - s0), 32'd1);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R5 reset pc", pc, 32'd0);
    chk("R5 reset ifid", ifid_instr, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    t_flow();
    t_rs_match();
    t_rt_match();
    t_no_read();
    t_other_fields();
    t_one_bubble();
    t_reset();
    t_flow();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule